// File: doc/BRIEF.md
# Circular Buffer Effective Address Generator

This block forms the effective address for one access through a pointer register and folds that address back into a circular buffer window whenever the arithmetic carries it past the active bound. A caller presents the pointer's current value, a signed byte step or offset, an addressing mode, the window's first and last word addresses, the buffer direction and a wrap enable. The block returns the address to put on the memory bus, together with a new pointer value and a strobe telling the register file to store it.

The bound test is a magnitude comparison. A step that lands anywhere beyond the bound is corrected by exactly one buffer length, not only a step that lands one word past it. An incrementing buffer is tested against its last address only, and a decrementing buffer against its first address only. The buffer length is the last address minus the first address plus one 16-bit word (2 bytes). The datapath is combinational. A parameter places one register stage on the outputs, which is the default.

Top module: `modaddr_circ_agu`

## Requirements
- R1: With wrap enabled and the direction input `buf_inc` at 1 (incrementing), a sum `ptr + step` (modulo 2^AW, unsigned) greater than `buf_last` is reduced by the length `buf_last - buf_first + 2`. This holds for any overshoot, including one larger than the step size.
- R2: With wrap enabled and `buf_inc` at 0 (decrementing), a sum less than `buf_first` is increased by the same length.
- R3: A sum equal to the active bound, or inside the window, passes through unchanged.
- R4: An incrementing buffer ignores the lower bound and a decrementing buffer ignores the upper bound. A sum beyond the inactive bound passes through unchanged.
- R5: In post-modify mode (`mode` = 0) the access address is the unmodified pointer, the write-back value is the corrected sum, and the strobe is raised.
- R6: In pre-modify mode (`mode` = 1) the access address and the write-back value are both the corrected sum, and the strobe is raised.
- R7: In register-offset mode (`mode` = 2, and the same for code 3) the access address is the corrected sum. The strobe stays low and the write-back value carries the unchanged pointer.
- R8: With `wrap_en` low, the access address is the plain sum modulo 2^AW with no correction.
- R9: With `req_valid` low the strobe stays low in every mode, and the addresses are still computed.
- R10: With REG_OUT=1 the outputs appear one clock after the inputs are presented. An active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is requested this cycle |
| mode | input | 2 | 0 post-modify, 1 pre-modify, 2/3 register offset |
| wrap_en | input | 1 | Enables circular correction |
| buf_inc | input | 1 | 1 incrementing buffer, 0 decrementing |
| ptr | input | AW | Current pointer register value |
| step | input | AW | Signed step or offset in bytes |
| buf_first | input | AW | First word address of the window |
| buf_last | input | AW | Last word address of the window |
| eff_addr | output | AW | Address used for the access |
| wb_data | output | AW | Value for the pointer register |
| wb_stb | output | 1 | Write the pointer register |

## Verification
The hardest cases to reach are steps that overshoot a bound by more than one word, and sums that land exactly on a bound. The stimulus creates them deliberately. It starts pointers at the last and first words of a 16-word window and applies steps of 2, 4 and 6 bytes in both directions. It also sends sums past the inactive bound to show that they are not touched. Windows of random placement and length, with in-range steps, then run against the bench model on every clock.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

    typedef enum logic [1:0] {
        AM_POST   = 2'd0,
        AM_PRE    = 2'd1,
        AM_OFFSET = 2'd2,
        AM_OFFALT = 2'd3
    } am_mode_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_DOWN  = 2'd1,
        WR_UP    = 2'd2
    } wrap_act_e;

endpackage

// File: rtl/modaddr_sum.sv
module modaddr_sum #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] delta,
    output logic [AW-1:0] total
);
    always_comb begin
        total = base + delta;
    end
endmodule

// File: rtl/modaddr_wrap.sv
module modaddr_wrap
    import modaddr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] raw,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          enable,
    input  logic          dir_up,
    output logic [AW-1:0] fixed,
    output wrap_act_e     act
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(2);

    logic [AW-1:0] span;

    always_comb begin
        span = hi - lo + WORD_BYTES;
    end

    always_comb begin
        act = WR_NONE;
        if (enable) begin
            if (dir_up) begin
                if (raw > hi) act = WR_UP;
            end else begin
                if (raw < lo) act = WR_DOWN;
            end
        end
    end

    always_comb begin
        unique case (act)
            WR_UP:   fixed = raw - span;
            WR_DOWN: fixed = raw + span;
            default: fixed = raw;
        endcase
    end
endmodule

// File: rtl/modaddr_route.sv
module modaddr_route
    import modaddr_pkg::*;
#(
    parameter int AW = 16
) (
    input  am_mode_e      am,
    input  logic          valid,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] cor,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb,
    output logic          stb
);
    always_comb begin
        unique case (am)
            AM_POST: begin
                ea  = cur;
                wb  = cor;
                stb = valid;
            end
            AM_PRE: begin
                ea  = cor;
                wb  = cor;
                stb = valid;
            end
            default: begin
                ea  = cor;
                wb  = cur;
                stb = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/modaddr_outreg.sv
module modaddr_outreg #(
    parameter int AW      = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ea_d,
    input  logic [AW-1:0] wb_d,
    input  logic          stb_d,
    output logic [AW-1:0] ea_q,
    output logic [AW-1:0] wb_q,
    output logic          stb_q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ea_q  <= '0;
                    wb_q  <= '0;
                    stb_q <= 1'b0;
                end else begin
                    ea_q  <= ea_d;
                    wb_q  <= wb_d;
                    stb_q <= stb_d;
                end
            end
        end else begin : g_comb
            always_comb begin
                ea_q  = ea_d;
                wb_q  = wb_d;
                stb_q = stb_d;
            end
        end
    endgenerate
endmodule

// File: rtl/modaddr_circ_agu.sv
module modaddr_circ_agu
    import modaddr_pkg::*;
#(
    parameter int AW      = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    mode,
    input  logic          wrap_en,
    input  logic          buf_inc,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] buf_first,
    input  logic [AW-1:0] buf_last,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] wb_data,
    output logic          wb_stb
);
    am_mode_e      am;
    logic [AW-1:0] raw_sum;
    logic [AW-1:0] cor_sum;
    wrap_act_e     wact;
    logic [AW-1:0] ea_c;
    logic [AW-1:0] wb_c;
    logic          stb_c;

    always_comb begin
        am = am_mode_e'(mode);
    end

    modaddr_sum #(.AW(AW)) u_sum (
        .base  (ptr),
        .delta (step),
        .total (raw_sum)
    );

    modaddr_wrap #(.AW(AW)) u_wrap (
        .raw    (raw_sum),
        .lo     (buf_first),
        .hi     (buf_last),
        .enable (wrap_en),
        .dir_up (buf_inc),
        .fixed  (cor_sum),
        .act    (wact)
    );

    modaddr_route #(.AW(AW)) u_route (
        .am    (am),
        .valid (req_valid),
        .cur   (ptr),
        .cor   (cor_sum),
        .ea    (ea_c),
        .wb    (wb_c),
        .stb   (stb_c)
    );

    modaddr_outreg #(.AW(AW), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ea_d  (ea_c),
        .wb_d  (wb_c),
        .stb_d (stb_c),
        .ea_q  (eff_addr),
        .wb_q  (wb_data),
        .stb_q (wb_stb)
    );

    // R3: in-window or on-bound sums are left alone (incrementing)
    assert_inwin_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_en && buf_inc && raw_sum <= buf_last) |-> (cor_sum == raw_sum));

    // R4: decrementing buffer ignores the upper bound
    assert_inwin_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_en && !buf_inc && raw_sum >= buf_first) |-> (cor_sum == raw_sum));

    // R8: disabled wrap means plain sum
    assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_en |-> (cor_sum == raw_sum && wact == WR_NONE));

    // R5: post-modify accesses the old pointer
    assert_post_ea_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (ea_c == ptr));

    // R6: pre-modify access and write-back agree
    assert_pre_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (ea_c == wb_c && wb_c == cor_sum));

    // R7: register-offset never writes the pointer
    assert_offset_nowb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |-> (!stb_c && wb_c == ptr));

    // R9: no strobe without a request
    assert_idle_nostb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !stb_c);

    generate
        if (REG_OUT) begin : g_lat_chk
            // R10: one-cycle output latency
            assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (eff_addr == $past(ea_c) && wb_stb == $past(stb_c)));
        end
    endgenerate
endmodule

// File: tb/modaddr_circ_agu_tb_top.sv
module modaddr_circ_agu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          wrap_en = 1'b0;
    logic          buf_inc = 1'b0;
    logic [AW-1:0] ptr = '0;
    logic [AW-1:0] step = '0;
    logic [AW-1:0] buf_first = '0;
    logic [AW-1:0] buf_last = '0;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] wb_data;
    logic          wb_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    ea;
        int    wb;
        int    stb;
        string tag;
    } exp_t;

    exp_t pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    modaddr_circ_agu #(.AW(AW), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .wrap_en(wrap_en), .buf_inc(buf_inc), .ptr(ptr), .step(step),
        .buf_first(buf_first), .buf_last(buf_last),
        .eff_addr(eff_addr), .wb_data(wb_data), .wb_stb(wb_stb)
    );

    task automatic check1(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input int v, input int m, input int en, input int inc,
                                   input int p, input int d, input int s, input int e,
                                   input string tag);
        exp_t r;
        int sum, len, fixv;
        sum  = (p + d) % 65536;
        if (sum < 0) sum += 65536;
        len  = (e - s + 2) % 65536;
        if (len < 0) len += 65536;
        fixv = sum;
        if (en != 0) begin
            if (inc != 0 && sum > e) fixv = (sum - len + 65536) % 65536;
            if (inc == 0 && sum < s) fixv = (sum + len) % 65536;
        end
        r.tag = tag;
        if (m == 0) begin r.ea = p;    r.wb = fixv; r.stb = v; end
        else if (m == 1) begin r.ea = fixv; r.wb = fixv; r.stb = v; end
        else begin r.ea = fixv; r.wb = p; r.stb = 0; end
        return r;
    endfunction

    task automatic compare_pending();
        exp_t x;
        if (pend.size() != 0) begin
            x = pend.pop_front();
            check1(x.tag, "eff_addr", int'(eff_addr), x.ea);
            check1(x.tag, "wb_data",  int'(wb_data),  x.wb);
            check1(x.tag, "wb_stb",   int'(wb_stb),   x.stb);
        end
    endtask

    task automatic apply(input int v, input int m, input int en, input int inc,
                         input int p, input int d, input int s, input int e,
                         input string tag);
        @(negedge clk);
        compare_pending();
        req_valid = v[0];
        mode      = m[1:0];
        wrap_en   = en[0];
        buf_inc   = inc[0];
        ptr       = p[AW-1:0];
        step      = d[AW-1:0];
        buf_first = s[AW-1:0];
        buf_last  = e[AW-1:0];
        pend.push_back(model(v, m, en, inc, p, d, s, e, tag));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check1("R10", "eff_addr reset", int'(eff_addr), 0);
        check1("R10", "wb_stb reset", int'(wb_stb), 0);
        rst_n = 1'b1;

        // R1: incrementing overshoot, steps 2, 4, 6 (window 0x1000..0x101E)
        apply(1, 1, 1, 1, 'h101E, 2, 'h1000, 'h101E, "R1");
        apply(1, 1, 1, 1, 'h101C, 4, 'h1000, 'h101E, "R1");
        apply(1, 1, 1, 1, 'h101E, 4, 'h1000, 'h101E, "R1");
        apply(1, 1, 1, 1, 'h101E, 6, 'h1000, 'h101E, "R1");
        // R2: decrementing undershoot, steps -2, -4, -6
        apply(1, 1, 1, 0, 'h1000, -2, 'h1000, 'h101E, "R2");
        apply(1, 1, 1, 0, 'h1002, -4, 'h1000, 'h101E, "R2");
        apply(1, 1, 1, 0, 'h1000, -6, 'h1000, 'h101E, "R2");
        // R3: landing exactly on a bound, and inside
        apply(1, 1, 1, 1, 'h101C, 2, 'h1000, 'h101E, "R3");
        apply(1, 1, 1, 0, 'h1002, -2, 'h1000, 'h101E, "R3");
        apply(1, 1, 1, 1, 'h1008, 4, 'h1000, 'h101E, "R3");
        // R4: inactive bound ignored
        apply(1, 1, 1, 1, 'h1000, -2, 'h1000, 'h101E, "R4");
        apply(1, 1, 1, 0, 'h101E, 4, 'h1000, 'h101E, "R4");
        // R5: post-modify, with and without wrap
        apply(1, 0, 1, 1, 'h101E, 2, 'h1000, 'h101E, "R5");
        apply(1, 0, 1, 0, 'h1000, -4, 'h1000, 'h101E, "R5");
        // R6: pre-modify
        apply(1, 1, 1, 0, 'h1000, -2, 'h1000, 'h101E, "R6");
        // R7: register offset, codes 2 and 3
        apply(1, 2, 1, 1, 'h101E, 4, 'h1000, 'h101E, "R7");
        apply(1, 3, 1, 0, 'h1000, -2, 'h1000, 'h101E, "R7");
        // R8: wrap disabled, including modulo rollover
        apply(1, 1, 0, 1, 'h101E, 6, 'h1000, 'h101E, "R8");
        apply(1, 0, 0, 0, 'h0002, -4, 'h1000, 'h101E, "R8");
        // R9: no request
        apply(0, 0, 1, 1, 'h101E, 2, 'h1000, 'h101E, "R9");
        apply(0, 1, 1, 0, 'h1000, -2, 'h1000, 'h101E, "R9");

        // random windows and in-range steps
        for (int i = 0; i < 400; i++) begin
            int words, s, e, off, d, inc, m;
            words = 2 + int'($urandom_range(30));
            s     = 'h0800 + 2 * int'($urandom_range(2000));
            e     = s + 2 * (words - 1);
            off   = 2 * int'($urandom_range(words - 1));
            d     = 2 * (int'($urandom_range(2 * words)) - words);
            inc   = int'($urandom_range(1));
            m     = int'($urandom_range(3));
            apply(int'($urandom_range(1)), m, int'($urandom_range(3)) != 0 ? 1 : 0,
                  inc, s + off, d, s, e, "R1 R2 random");
        end

        @(negedge clk);
        compare_pending();

        // R10: reset clears registered outputs
        rst_n = 1'b0;
        @(negedge clk);
        check1("R10", "wb_data after reset", int'(wb_data), 0);
        check1("R10", "wb_stb after reset", int'(wb_stb), 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule